// File: doc/BRIEF.md
# Three-Wire Serial Nonvolatile Memory Slave

This block is the slave side of a three-wire serial memory. The memory contents are held in on-chip registers. The host lowers and raises a chip select, toggles a serial clock and shifts bits in on a data input. The block answers on a data output, which has an enable so the pin can float.

Each instruction opens with a start bit. A 2-bit opcode follows, then an address field, then a data field if the instruction carries one. Seven instructions are supported:

- read;
- write of one location and erase of one location;
- write of all locations and erase of all locations;
- enable and disable of programming.

A write-enable latch guards every instruction that changes the memory. Programming is self-timed by a counter that runs on the system clock. While it runs, the host can poll ready/busy on the data output after it has cycled chip select.

The serial inputs are sampled in the system clock domain. A rising serial clock is seen as a low-to-high change between two samples. The default organization is byte-wide. A parameter gives a word-wide variant with a 7-bit address and 16 data bits.

Top module: `uwire_eeprom`

## Requirements
- R1: While chip select is high and no instruction is open, rising serial clocks with data in low change nothing. The first rising edge that samples data in high is taken as the start bit.
- R2: The two bits after the start bit are the opcode: 10 is read, 01 is write, 11 is erase. For opcode 00, the first two bits of the address field choose the command: 11 enables programming, 00 disables it, 10 erases all, 01 writes all.
- R3: In byte organization the address field is 9 bits, a don't-care bit followed by address bits 7..0, MSB first. Instructions without data take 12 rising edges counting the start bit. Write and write-all take 20, with 8 data bits MSB first.
- R4: The write-enable latch is clear after reset. Erase, erase-all, write and write-all leave the memory unchanged unless an enable has run with no disable after it.
- R5: On the rising edge that carries the last address bit of a read, data out becomes a dummy 0 with the enable high. Each later rising edge presents the next data bit, MSB first. After the LSB, reading continues with the next address, and the address wraps from 255 to 0.
- R6: Erase sets one location to all ones. Erase-all sets every location to all ones. Write-all stores the data pattern in every location.
- R7: A single-location operation stays busy for T_PROG system clocks and an all-location operation for T_BULK. The memory changes only when the busy period ends.
- R8: Once programming has started, and chip select has gone low and then high again, data out is enabled. It reads 0 while busy and 1 when done. It stays enabled until the next start bit is accepted.
- R9: The data output enable is low after reset, while chip select is low, and after enable or disable commands.
- R10: Chip select low abandons a partly shifted instruction. A programming cycle that has already started still completes.
- R11: Once an instruction has all its bits, further clocks and data are ignored until chip select goes low.
- R12: While programming is busy, a start bit is not accepted, so the ready/busy status stays on data out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock, sampled by clk |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out |
| do_oe | output | 1 | Output enable for do_o; low means high-impedance |

## Verification
The bench probes with a start bit while programming is busy. A design that accepted that start bit would drop the ready/busy status and begin a fresh instruction. It also cuts a write one data bit short, and then sends extra clocks after a complete write. A design that counted frames wrongly would either program the truncated write or overwrite the stored value with the extra bits. A sequential read across the top address checks both the wrap to address 0 and the absence of a second dummy bit. A write-all is timed against the longer bulk period, which exposes a design that uses the single-location time for it. Writes attempted before enable and after disable catch a latch that is reset or gated wrongly.

// File: rtl/uwire_eeprom.sv
module uwire_eeprom #(
  parameter bit WORD_ORG = 1'b0,
  parameter int T_PROG   = 24,
  parameter int T_BULK   = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  localparam int DW    = WORD_ORG ? 16 : 8;
  localparam int AW    = WORD_ORG ? 7 : 8;
  localparam int DEPTH = 1 << AW;
  localparam int NHDR  = 3 + AW;
  localparam int NALL  = NHDR + DW;
  localparam int CW    = $clog2(NALL + 1);
  localparam int TMAX  = (T_PROG > T_BULK) ? T_PROG : T_BULK;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int IW    = $clog2(DW);
  localparam logic [1:0] S_IDLE = 2'd0, S_CMD = 2'd1, S_READ = 2'd2, S_HOLD = 2'd3;

  logic [1:0]      phase;
  logic [CW-1:0]   cnt;
  logic [NALL-2:0] sr;
  logic            sclk_q, wen, busy, bulk, arm, vis, do_r;
  logic [TW-1:0]   pcnt;
  logic [AW-1:0]   paddr, rd_addr;
  logic [DW-1:0]   pdata, rd_sh;
  logic [IW-1:0]   rd_idx;
  logic [DW-1:0]   mem [DEPTH];

  wire            rise     = cs & sclk & ~sclk_q;
  wire [NALL-1:0] sr_n     = {sr, di};
  wire [CW-1:0]   cnt_n    = cnt + 1'b1;
  wire            hdr_done = (cnt_n == CW'(NHDR));
  wire            dat_done = (cnt_n == CW'(NALL));
  wire [1:0]      op       = sr_n[NHDR-1 -: 2];
  wire [1:0]      sub      = sr_n[AW -: 2];
  wire [AW-1:0]   hadr     = sr_n[AW-1:0];
  wire [1:0]      op_d     = sr_n[NALL-1 -: 2];
  wire [1:0]      sub_d    = sr_n[DW+AW -: 2];
  wire [AW-1:0]   adr_d    = sr_n[DW +: AW];

  logic          launch, l_bulk;
  logic [AW-1:0] l_addr;
  logic [DW-1:0] l_data;

  always_comb begin
    launch = 1'b0;
    l_bulk = 1'b0;
    l_addr = hadr;
    l_data = '1;
    if (rise && phase == S_CMD && wen) begin
      if (hdr_done && op == 2'b11) launch = 1'b1;
      if (hdr_done && op == 2'b00 && sub == 2'b10) begin
        launch = 1'b1;
        l_bulk = 1'b1;
      end
      if (dat_done && op_d == 2'b01) begin
        launch = 1'b1;
        l_addr = adr_d;
        l_data = sr_n[DW-1:0];
      end
      if (dat_done && op_d == 2'b00 && sub_d == 2'b01) begin
        launch = 1'b1;
        l_bulk = 1'b1;
        l_data = sr_n[DW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (busy && pcnt == '0) begin
      for (int i = 0; i < DEPTH; i++)
        if (bulk || paddr == AW'(i)) mem[i] <= pdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= S_IDLE;
      cnt     <= '0;
      sr      <= '0;
      sclk_q  <= 1'b0;
      wen     <= 1'b0;
      busy    <= 1'b0;
      bulk    <= 1'b0;
      pcnt    <= '0;
      paddr   <= '0;
      pdata   <= '0;
      arm     <= 1'b0;
      vis     <= 1'b0;
      do_r    <= 1'b0;
      rd_sh   <= '0;
      rd_addr <= '0;
      rd_idx  <= '0;
    end else begin
      sclk_q <= sclk;
      if (busy) begin
        if (pcnt == '0) busy <= 1'b0;
        else pcnt <= pcnt - 1'b1;
      end
      if (launch) begin
        busy  <= 1'b1;
        bulk  <= l_bulk;
        paddr <= l_addr;
        pdata <= l_data;
        pcnt  <= l_bulk ? TW'(T_BULK - 1) : TW'(T_PROG - 1);
        arm   <= 1'b1;
      end
      if (!cs) begin
        phase <= S_IDLE;
        cnt   <= '0;
        if (arm) vis <= 1'b1;
      end else if (rise) begin
        case (phase)
          S_IDLE: if (di && !busy) begin
            phase <= S_CMD;
            cnt   <= '0;
            sr    <= '0;
            arm   <= 1'b0;
            vis   <= 1'b0;
          end
          S_CMD: begin
            sr  <= sr_n[NALL-2:0];
            cnt <= cnt_n;
            if (hdr_done) begin
              case (op)
                2'b10: begin
                  phase   <= S_READ;
                  do_r    <= 1'b0;
                  rd_sh   <= mem[hadr];
                  rd_addr <= hadr;
                  rd_idx  <= '0;
                end
                2'b01: ;
                2'b11: phase <= S_HOLD;
                default: begin
                  if (sub == 2'b11) wen <= 1'b1;
                  else if (sub == 2'b00) wen <= 1'b0;
                  if (sub != 2'b01) phase <= S_HOLD;
                end
              endcase
            end
            if (dat_done) phase <= S_HOLD;
          end
          S_READ: begin
            do_r <= rd_sh[DW-1];
            if (rd_idx == IW'(DW - 1)) begin
              rd_idx  <= '0;
              rd_addr <= rd_addr + 1'b1;
              rd_sh   <= mem[rd_addr + 1'b1];
            end else begin
              rd_idx <= rd_idx + 1'b1;
              rd_sh  <= rd_sh << 1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign do_oe = cs & ((phase == S_READ) | vis);
  assign do_o  = (phase == S_READ) ? do_r : ~busy;

endmodule

// File: rtl/uwire_eeprom_chk.sv
module uwire_eeprom_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          do_oe,
  input logic          busy,
  input logic          wen,
  input logic [1:0]    phase,
  input logic [DW-1:0] mem0
);
  p_wen_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen));

  p_no_status_at_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !do_oe);

  p_busy_blocks_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase == 2'd0) |=> phase != 2'd1);

  p_cs_low_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> phase == 2'd0);

  p_hold_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && cs) |=> phase == 2'd3);

  p_mem_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(mem0));
endmodule

bind uwire_eeprom uwire_eeprom_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .do_oe(do_oe), .busy(busy),
  .wen(wen), .phase(phase), .mem0(mem[0])
);

// File: tb/uwire_eeprom_test.sv
module uwire_eeprom_test;
  localparam int CLK_PER = 10;
  localparam int TP = 24;
  localparam int TB = 64;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, di = 1'b0;
  logic do_o, do_oe;
  int total = 0, bad = 0;
  bit done = 1'b0;

  uwire_eeprom #(.WORD_ORG(1'b0), .T_PROG(TP), .T_BULK(TB)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .di(di),
    .do_o(do_o), .do_oe(do_oe)
  );

  always #(CLK_PER/2) clk = ~clk;

  // behavioural reference
  int m_st, m_left, m_paddr, m_pdata, m_rda, m_rdi, m_op, m_sub, m_adr;
  bit m_sq, m_wen, m_bulk, m_arm, m_vis, m_dobit;
  int m_mem[256];
  bit q[$];

  task automatic m_launch(input bit b, input int a, input int d);
    m_left = b ? TB : TP; m_bulk = b; m_paddr = a; m_pdata = d; m_arm = 1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_left = 0; m_sq = 0; m_wen = 0; m_arm = 0; m_vis = 0; m_dobit = 0;
      foreach (m_mem[i]) m_mem[i] = 255;
      q.delete();
    end else begin
      bit rise, wb;
      rise = cs && sclk && !m_sq;
      m_sq = sclk;
      wb = m_left > 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin
          if (m_bulk) foreach (m_mem[i]) m_mem[i] = m_pdata;
          else m_mem[m_paddr] = m_pdata;
        end
      end
      if (!cs) begin
        m_st = 0;
        if (m_arm) m_vis = 1;
      end else if (rise) begin
        case (m_st)
          0: if (di && !wb) begin m_st = 1; q.delete(); m_arm = 0; m_vis = 0; end
          1: begin
            q.push_back(di);
            if (q.size() == 11) begin
              m_op = 2*q[0] + q[1];
              m_sub = 2*q[2] + q[3];
              m_adr = 0;
              for (int k = 3; k < 11; k++) m_adr = m_adr*2 + q[k];
              case (m_op)
                2: begin m_st = 2; m_dobit = 0; m_rda = m_adr; m_rdi = 7; end
                3: begin if (m_wen) m_launch(0, m_adr, 255); m_st = 3; end
                0: begin
                  if (m_sub == 3) m_wen = 1;
                  if (m_sub == 0) m_wen = 0;
                  if (m_sub == 2 && m_wen) m_launch(1, 0, 255);
                  if (m_sub != 1) m_st = 3;
                end
                default: ;
              endcase
            end else if (q.size() == 19) begin
              int d;
              d = 0;
              for (int k = 11; k < 19; k++) d = d*2 + q[k];
              if (m_wen && m_op == 1) m_launch(0, m_adr, d);
              if (m_wen && m_op == 0) m_launch(1, 0, d);
              m_st = 3;
            end
          end
          2: begin
            m_dobit = (m_mem[m_rda] >> m_rdi) & 1;
            if (m_rdi == 0) begin m_rdi = 7; m_rda = (m_rda + 1) % 256; end
            else m_rdi--;
          end
          default: ;
        endcase
      end
      #2;
      begin
        bit eoe, edo;
        eoe = cs && (m_st == 2 || m_vis);
        edo = (m_st == 2) ? m_dobit : (m_left == 0);
        total++;
        if (do_oe !== eoe) begin
          bad++;
          $display("FAIL R9 per-clock enable act=%0b exp=%0b t=%0t", do_oe, eoe, $time);
        end else if (eoe && do_o !== edo) begin
          bad++;
          $display("FAIL R5/R8 per-clock data act=%0b exp=%0b t=%0t", do_o, edo, $time);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input bit d);
    di = d; sclk = 1'b0;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input int n, input logic [31:0] v);
    for (int i = n - 1; i >= 0; i--) tick(v[i]);
  endtask

  task automatic cs_low;
    sclk = 1'b0; cs = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_high;
    cs = 1'b1;
    @(negedge clk);
  endtask

  task automatic instr(input logic [1:0] op, input logic [8:0] fld);
    cs_low; cs_high;
    tick(1'b1);
    send(2, op);
    send(9, fld);
  endtask

  task automatic wait_ready;
    for (int k = 0; k < 300 && !(do_oe && do_o); k++) @(negedge clk);
  endtask

  task automatic rd(input int a, input int n, output int w0, output int w1);
    int w;
    instr(2'b10, {1'b0, 8'(a)});
    chk(do_oe && do_o == 1'b0, "R5 dummy zero", {do_oe, do_o}, 2);
    w0 = 0; w1 = 0;
    for (int j = 0; j < n; j++) begin
      w = 0;
      for (int b = 0; b < 8; b++) begin
        tick(1'b0);
        w = w*2 + do_o;
      end
      if (j == 0) w0 = w; else w1 = w;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int r0, r1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(do_oe == 1'b0, "R9 reset enable", do_oe, 0);

    // R4: write before enable has no effect
    cs_high; send(3, 3'b000);
    instr(2'b01, 9'd3); send(8, 8'h5A);
    cs_low; cs_high;
    chk(do_oe == 1'b0, "R4 no launch without enable", do_oe, 0);
    rd(3, 1, r0, r1);
    chk(r0 == 8'hFF, "R4 locked write", r0, 8'hFF);

    // R2/R9: enable, no status on data out
    instr(2'b00, {2'b11, 7'd0});
    cs_low; cs_high;
    chk(do_oe == 1'b0, "R9 enable command floats", do_oe, 0);

    // R1/R3/R8/R12: write preceded by idle zero clocks
    cs_low; cs_high; send(4, 4'b0000);
    tick(1'b1); send(2, 2'b01); send(9, 9'd3); send(8, 8'hA5);
    chk(do_oe == 1'b0, "R8 no status before cs cycle", do_oe, 0);
    cs_low; cs_high;
    chk(do_oe && do_o == 1'b0, "R8 busy status", {do_oe, do_o}, 2);
    tick(1'b1);
    chk(do_oe && do_o == 1'b0, "R12 start ignored while busy", {do_oe, do_o}, 2);
    cs_low; cs_high;
    wait_ready;
    chk(do_oe && do_o, "R7 ready after single write", {do_oe, do_o}, 3);
    rd(3, 1, r0, r1);
    chk(r0 == 8'hA5, "R1 R3 write landed", r0, 8'hA5);

    // R11: extra clocks after a full write
    instr(2'b01, 9'd5); send(8, 8'h3C); send(8, 8'hFF);
    cs_low; cs_high; wait_ready;
    rd(5, 1, r0, r1);
    chk(r0 == 8'h3C, "R11 trailing clocks ignored", r0, 8'h3C);

    // R10: truncated write abandoned
    instr(2'b01, 9'd6); send(7, 7'h00);
    cs_low; cs_high;
    chk(do_oe == 1'b0, "R10 no launch on partial frame", do_oe, 0);
    rd(6, 1, r0, r1);
    chk(r0 == 8'hFF, "R10 partial write", r0, 8'hFF);

    // R6: erase one
    instr(2'b11, 9'd3);
    cs_low; cs_high; wait_ready;
    rd(3, 1, r0, r1);
    chk(r0 == 8'hFF, "R6 erase", r0, 8'hFF);

    // R6/R7: write-all with bulk timing
    instr(2'b00, {2'b01, 7'd0}); send(8, 8'h69);
    cs_low; cs_high;
    repeat (30) @(negedge clk);
    chk(do_oe && do_o == 1'b0, "R7 bulk still busy", {do_oe, do_o}, 2);
    wait_ready;
    rd(200, 1, r0, r1);
    chk(r0 == 8'h69, "R6 write-all", r0, 8'h69);

    // R5: sequential read wraps
    instr(2'b01, 9'd0); send(8, 8'h12);
    cs_low; cs_high; wait_ready;
    rd(255, 2, r0, r1);
    chk(r0 == 8'h69, "R5 first word", r0, 8'h69);
    chk(r1 == 8'h12, "R5 wrapped word", r1, 8'h12);

    // R6: erase-all
    instr(2'b00, {2'b10, 7'd0});
    cs_low; cs_high; wait_ready;
    rd(0, 1, r0, r1);
    chk(r0 == 8'hFF, "R6 erase-all", r0, 8'hFF);

    // R4: disable then write
    instr(2'b00, {2'b00, 7'd0});
    instr(2'b01, 9'd7); send(8, 8'h00);
    cs_low; cs_high;
    rd(7, 1, r0, r1);
    chk(r0 == 8'hFF, "R4 disabled write", r0, 8'hFF);

    cs_low;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule